// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block moves fixed-length words over a pair of external serial clocks: one for reception and one for transmission. On the receive side, a shift register collects one bit on each rising edge of the receive clock, most significant bit first. Each finished word is copied into a holding register that software reads. On the transmit side, software writes a word into a buffer register. The buffer feeds a shift register that puts the word onto the serial line, most significant bit first.

Both directions are double-buffered. While one word is on the wire, the next word can be written or read. The transmit-empty and receive-full lines are brought out to the pins, so they can drive an interrupt or a DMA request. A status word records two error conditions: a transmit underrun and a receive overrun.

The serial clocks are not used as clocks inside the block. Each one passes through a synchronizer into the system clock domain. The rising edge of the synchronized clock then acts as a one-cycle bit enable.

A small register port gives access to the block. The port has a 2-bit address, a write strobe, a read strobe, write data, and combinational read data.

Top module: `sync_serial_port`

## Requirements
- R1: A word is WORD_W bits long (16 by default). The receiver takes one bit per rising edge of the synchronized receive clock, most significant bit first. The data bit is sampled through the same number of synchronizer stages as the clock.
- R2: When the last bit of a word arrives, the word is copied into the receive holding register. A read at address 0 returns this register. The register changes at no other time, and a write to address 0 has no effect on it.
- R3: The receive-full flag goes high when a word is copied into the holding register. A read strobe at address 0 clears it. The flag appears at status bit 0 and on `rx_full_o`. If a word finishes in the same cycle as the read, the flag stays set.
- R4: If a word finishes while the receive-full flag is set and no read happens in that cycle, the new word overwrites the old one and sticky status bit 3 (overrun) is set. Writing a 1 to status bit 3 at address 2 clears it; the set wins if both happen in the same cycle.
- R5: `tx_sd_o` always shows the most significant bit of the transmit shift register. The register moves by one bit only on a rising edge of the synchronized transmit clock.
- R6: If the buffer holds a word when the last bit has been sent, that word is loaded into the shift register on the very next transmit-clock edge. There is no idle bit between the two words and no underrun.
- R7: The transmit-empty flag is high after reset. It goes high when the buffer contents move into the shift register, and goes low on a write to address 1; the write wins if both happen in the same cycle. The flag appears at status bit 1 and on `tx_empty_o`.
- R8: If the last bit has been sent and the buffer is empty, sticky status bit 2 (underrun) is set and the line keeps its last bit value until a new word is loaded. Writing a 1 to status bit 2 at address 2 clears the bit.
- R9: After reset, the status word at address 2 reads 0x0002, the holding register reads 0, and `tx_sd_o` is 0. Addresses 1 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sclk_i | input | 1 | External receive bit clock |
| rx_sd_i | input | 1 | Serial receive data |
| tx_sclk_i | input | 1 | External transmit bit clock |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_empty_o | output | 1 | Transmit buffer empty (interrupt / DMA request) |
| rx_full_o | output | 1 | Receive holding register holds unread data |
| reg_addr_i | input | 2 | Register address: 0 receive holding, 1 transmit buffer, 2 status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears receive-full at address 0) |
| reg_wdata_i | input | WORD_W | Register write data |
| reg_rdata_o | output | WORD_W | Register read data |

## Verification
The bench builds the port with WORD_W = 8 and SYNC_STAGES = 2. The shorter word keeps each word on the wire to about fifty system cycles. That puts these cases within a short run: back-to-back transmission, a deliberate underrun with the held line level, and two received words landing without a read in between. Keeping two synchronizer stages exercises the delay of more than one cycle between a serial edge and its bit enable. The per-cycle model has to reproduce that delay exactly.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ADDR_RXHOLD = 2'd0,
        ADDR_TXBUF  = 2'd1,
        ADDR_STATUS = 2'd2,
        ADDR_SPARE  = 2'd3
    } ssp_addr_e;

    localparam int ST_RX_FULL  = 0;
    localparam int ST_TX_EMPTY = 1;
    localparam int ST_TX_UDR   = 2;
    localparam int ST_RX_OVR   = 3;
    localparam int ST_BITS     = 4;

endpackage

// File: rtl/ssp_sync_edge.sv
module ssp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sd_i,
    output logic rise_o,
    output logic sd_o
);
    typedef struct packed {
        logic [STAGES-1:0] clk_s;
        logic [STAGES-1:0] dat_s;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.clk_s = {st_q.clk_s[STAGES-2:0], sclk_i};
        st_d.dat_s = {st_q.dat_s[STAGES-2:0], sd_i};
        st_d.prev  = st_q.clk_s[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.clk_s[STAGES-1] & ~st_q.prev;
    assign sd_o   = st_q.dat_s[STAGES-1];
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              bit_i,
    input  logic              rd_hold_i,
    input  logic              clr_ovr_i,
    output logic [WORD_W-1:0] hold_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              done_o
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] hold;
        logic              full;
        logic              ovr;
    } rx_t;

    rx_t st_d, st_q;
    logic [WORD_W-1:0] shifted;
    logic done;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.shreg[WORD_W-2:0], bit_i};
        done    = bit_en_i && (st_q.cnt == LAST);
        if (bit_en_i) begin
            st_d.shreg = shifted;
            st_d.cnt   = done ? '0 : st_q.cnt + 1'b1;
        end
        if (clr_ovr_i) st_d.ovr = 1'b0;
        if (done) begin
            st_d.hold = shifted;
            st_d.full = 1'b1;
            if (st_q.full && !rd_hold_i) st_d.ovr = 1'b1;
        end else if (rd_hold_i) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign full_o = st_q.full;
    assign ovr_o  = st_q.ovr;
    assign done_o = done;
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              clr_udr_i,
    output logic              sd_o,
    output logic              empty_o,
    output logic              udr_o,
    output logic              load_o,
    output logic              active_o
);
    localparam int CW = $clog2(WORD_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] buffer;
        logic [WORD_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic              active;
        logic              empty;
        logic              udr;
    } tx_t;

    tx_t  st_d, st_q;
    logic last, load, set_udr;

    always_comb begin
        st_d    = st_q;
        last    = st_q.active && (st_q.cnt == LAST);
        load    = bit_en_i && !st_q.empty && (!st_q.active || last);
        set_udr = 1'b0;
        if (load) begin
            st_d.sh     = st_q.buffer;
            st_d.cnt    = '0;
            st_d.active = 1'b1;
            st_d.empty  = 1'b1;
        end else if (bit_en_i && last) begin
            st_d.active = 1'b0;
            set_udr     = 1'b1;
        end else if (bit_en_i && st_q.active) begin
            st_d.sh  = {st_q.sh[WORD_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wr_i) begin
            st_d.buffer = wdata_i;
            st_d.empty  = 1'b0;
        end
        if (clr_udr_i) st_d.udr = 1'b0;
        if (set_udr)   st_d.udr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sd_o     = st_q.sh[WORD_W-1];
    assign empty_o  = st_q.empty;
    assign udr_o    = st_q.udr;
    assign load_o   = load;
    assign active_o = st_q.active;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_sclk_i,
    input  logic              rx_sd_i,
    input  logic              tx_sclk_i,
    output logic              tx_sd_o,
    output logic              tx_empty_o,
    output logic              rx_full_o,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o
);
    localparam int PAD_W = WORD_W - ST_BITS;

    logic rx_bit_en, rx_bit, tx_bit_en, tx_unused_sd;
    logic rx_done, rx_ovr, rx_rd, clr_ovr;
    logic tx_wr, tx_load, tx_udr, tx_active, clr_udr;
    logic [WORD_W-1:0] rx_hold;
    logic [ST_BITS-1:0] status;

    ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(rx_sclk_i), .sd_i(rx_sd_i),
        .rise_o(rx_bit_en), .sd_o(rx_bit)
    );

    ssp_sync_edge #(.STAGES(SYNC_STAGES)) u_tx_sync (
        .clk(clk), .rst_n(rst_n), .sclk_i(tx_sclk_i), .sd_i(1'b0),
        .rise_o(tx_bit_en), .sd_o(tx_unused_sd)
    );

    assign rx_rd   = reg_rd_i && (ssp_addr_e'(reg_addr_i) == ADDR_RXHOLD);
    assign tx_wr   = reg_wr_i && (ssp_addr_e'(reg_addr_i) == ADDR_TXBUF);
    assign clr_ovr = reg_wr_i && (ssp_addr_e'(reg_addr_i) == ADDR_STATUS) && reg_wdata_i[ST_RX_OVR];
    assign clr_udr = reg_wr_i && (ssp_addr_e'(reg_addr_i) == ADDR_STATUS) && reg_wdata_i[ST_TX_UDR];

    ssp_rx #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_en_i(rx_bit_en), .bit_i(rx_bit),
        .rd_hold_i(rx_rd), .clr_ovr_i(clr_ovr),
        .hold_o(rx_hold), .full_o(rx_full_o), .ovr_o(rx_ovr), .done_o(rx_done)
    );

    ssp_tx #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_en_i(tx_bit_en), .wr_i(tx_wr),
        .wdata_i(reg_wdata_i), .clr_udr_i(clr_udr),
        .sd_o(tx_sd_o), .empty_o(tx_empty_o), .udr_o(tx_udr),
        .load_o(tx_load), .active_o(tx_active)
    );

    always_comb begin
        status              = '0;
        status[ST_RX_FULL]  = rx_full_o;
        status[ST_TX_EMPTY] = tx_empty_o;
        status[ST_TX_UDR]   = tx_udr;
        status[ST_RX_OVR]   = rx_ovr;
        case (ssp_addr_e'(reg_addr_i))
            ADDR_RXHOLD: reg_rdata_o = rx_hold;
            ADDR_STATUS: reg_rdata_o = {{PAD_W{1'b0}}, status};
            default:     reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic              rx_full,
    input logic [WORD_W-1:0] rx_hold,
    input logic              rx_ovr,
    input logic              clr_ovr,
    input logic              tx_bit_en,
    input logic              tx_load,
    input logic              tx_wr,
    input logic              tx_empty,
    input logic              tx_udr,
    input logic              clr_udr,
    input logic              tx_active,
    input logic              tx_sd
);
    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(rx_hold));

    assert_full_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_full);

    assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && !clr_ovr) |=> rx_ovr);

    assert_line_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_bit_en |=> $stable(tx_sd));

    assert_empty_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && !tx_wr) |=> tx_empty);

    assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_empty);

    assert_udr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_udr && !clr_udr) |=> tx_udr);

    assert_idle_line_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && tx_empty) |=> $stable(tx_sd));
endmodule

bind sync_serial_port ssp_checker #(.WORD_W(WORD_W)) u_ssp_checker (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_full(rx_full_o),
    .rx_hold(rx_hold), .rx_ovr(rx_ovr), .clr_ovr(clr_ovr),
    .tx_bit_en(tx_bit_en), .tx_load(tx_load), .tx_wr(tx_wr),
    .tx_empty(tx_empty_o), .tx_udr(tx_udr), .clr_udr(clr_udr),
    .tx_active(tx_active), .tx_sd(tx_sd_o)
);

// File: tb/sync_serial_port_tb_top.sv
module sync_serial_port_tb_top;
    localparam int W = 8;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_sclk = 1'b0, rx_sd = 1'b0, tx_sclk = 1'b0;
    logic tx_sd, tx_empty, rx_full;
    logic [1:0] addr = 2'd0;
    logic wr = 1'b0, rd = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    sync_serial_port #(.WORD_W(W), .SYNC_STAGES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_sclk_i(rx_sclk), .rx_sd_i(rx_sd),
        .tx_sclk_i(tx_sclk), .tx_sd_o(tx_sd), .tx_empty_o(tx_empty),
        .rx_full_o(rx_full), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata)
    );

    // reference model state
    int rxc_h[$], rxd_h[$], txc_h[$];
    logic [W-1:0] m_rsh, m_hold, m_buf, m_tsh;
    int m_rcnt, m_tcnt;
    logic m_full, m_ovr, m_empty, m_udr, m_act;

    // serial stimulus generators
    int div = 0;
    int rx_bits[$];
    bit rx_loaded = 0;
    bit tx_run = 0;

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        rxc_h = {}; rxd_h = {}; txc_h = {};
        for (int i = 0; i <= S; i++) begin
            rxc_h.push_back(0); rxd_h.push_back(0); txc_h.push_back(0);
        end
        m_rsh = '0; m_hold = '0; m_buf = '0; m_tsh = '0;
        m_rcnt = 0; m_tcnt = 0;
        m_full = 0; m_ovr = 0; m_empty = 1; m_udr = 0; m_act = 0;
    endtask

    task automatic model_step();
        bit rx_rise, tx_rise, rbit, finish, last, ld, set_u, set_o;
        if (!rst_n) begin
            model_reset();
            return;
        end
        rx_rise = (rxc_h[S-1] == 1) && (rxc_h[S] == 0);
        rbit    = rxd_h[S-1][0];
        tx_rise = (txc_h[S-1] == 1) && (txc_h[S] == 0);
        // receive side
        finish = rx_rise && (m_rcnt == W-1);
        set_o  = 0;
        if (rx_rise) begin
            m_rsh  = {m_rsh[W-2:0], rbit};
            m_rcnt = finish ? 0 : m_rcnt + 1;
        end
        if (finish) begin
            if (m_full && !(rd && addr == 2'd0)) set_o = 1;
            m_hold = m_rsh;
            m_full = 1;
        end else if (rd && addr == 2'd0) begin
            m_full = 0;
        end
        if (wr && addr == 2'd2 && wdata[3]) m_ovr = 0;
        if (set_o) m_ovr = 1;
        // transmit side
        last  = m_act && (m_tcnt == W-1);
        ld    = tx_rise && !m_empty && (!m_act || last);
        set_u = 0;
        if (ld) begin
            m_tsh = m_buf; m_tcnt = 0; m_act = 1; m_empty = 1;
        end else if (tx_rise && last) begin
            m_act = 0; set_u = 1;
        end else if (tx_rise && m_act) begin
            m_tsh = m_tsh << 1; m_tcnt++;
        end
        if (wr && addr == 2'd1) begin
            m_buf = wdata; m_empty = 0;
        end
        if (wr && addr == 2'd2 && wdata[2]) m_udr = 0;
        if (set_u) m_udr = 1;
        // record inputs applied at the coming edge
        rxc_h.push_front(int'(rx_sclk)); rxc_h.pop_back();
        rxd_h.push_front(int'(rx_sd));   rxd_h.pop_back();
        txc_h.push_front(int'(tx_sclk)); txc_h.pop_back();
    endtask

    task automatic compare();
        int exp_rd;
        case (addr)
            2'd0:    exp_rd = int'(m_hold);
            2'd2:    exp_rd = {m_ovr, m_udr, m_empty, m_full};
            default: exp_rd = 0;
        endcase
        check(addr == 2'd2 ? "R9 status word" : "R2 read data", int'(rdata), exp_rd);
        check("R5 serial line", int'(tx_sd), int'(m_tsh[W-1]));
        check("R7 transmit empty", int'(tx_empty), int'(m_empty));
        check("R3 receive full", int'(rx_full), int'(m_full));
    endtask

    task automatic tick();
        div++;
        if (div == 3) begin
            div = 0;
            if (rx_sclk) begin
                rx_sclk = 0;
                if (rx_bits.size() > 0) begin rx_sd = rx_bits.pop_front()[0]; rx_loaded = 1; end
            end else if (rx_loaded) begin
                rx_sclk = 1; rx_loaded = 0;
            end else if (rx_bits.size() > 0) begin
                rx_sd = rx_bits.pop_front()[0]; rx_loaded = 1;
            end
            if (tx_run) tx_sclk = ~tx_sclk;
        end
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic reg_write(logic [1:0] a, logic [W-1:0] d);
        addr = a; wdata = d; wr = 1;
        tick();
        wr = 0;
    endtask

    task automatic reg_read(logic [1:0] a);
        addr = a; rd = 1;
        tick();
        rd = 0;
    endtask

    task automatic send_word(logic [W-1:0] w);
        for (int i = W-1; i >= 0; i--) rx_bits.push_back(int'(w[i]));
    endtask

    task automatic wait_rx_idle();
        while (rx_bits.size() > 0 || rx_loaded) tick();
        ticks(S + 4);
    endtask

    task automatic wait_empty_rise();
        int guard = 0;
        while (tx_empty == 1 && guard < 200) begin tick(); guard++; end
        while (tx_empty == 0 && guard < 400) begin tick(); guard++; end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    initial begin
        logic held;
        model_reset();
        ticks(4);
        rst_n = 1;
        addr = 2'd2;
        tick();
        check("R9 reset status", int'(rdata), 2);
        addr = 2'd0; #1;
        check("R9 reset holding", int'(rdata), 0);
        check("R9 reset line", int'(tx_sd), 0);

        // receive one word
        send_word(8'hA5);
        wait_rx_idle();
        check("R3 full after word", int'(rx_full), 1);
        addr = 2'd0; #1;
        check("R1 msb-first word", int'(rdata), 8'hA5);
        reg_read(2'd0);
        check("R3 read clears full", int'(rx_full), 0);

        // write to the read-only holding register
        reg_write(2'd0, 8'h5A);
        addr = 2'd0; #1;
        check("R2 holding ignores write", int'(rdata), 8'hA5);

        // overrun
        send_word(8'h3C);
        send_word(8'hC3);
        wait_rx_idle();
        addr = 2'd2; #1;
        check("R4 overrun flag", int'(rdata[3]), 1);
        addr = 2'd0; #1;
        check("R4 newest word kept", int'(rdata), 8'hC3);
        reg_write(2'd2, 8'h08);
        addr = 2'd2; #1;
        check("R4 overrun cleared", int'(rdata[3]), 0);
        reg_read(2'd0);

        // transmit with reload, then underrun
        reg_write(2'd1, 8'h96);
        check("R7 write clears empty", int'(tx_empty), 0);
        tx_run = 1;
        wait_empty_rise();
        check("R5 first bit is msb", int'(tx_sd), 1);
        reg_write(2'd1, 8'h0F);
        wait_empty_rise();
        addr = 2'd2; #1;
        check("R6 no underrun on reload", int'(rdata[2]), 0);
        check("R6 next word msb follows", int'(tx_sd), 0);
        ticks(6 * W + 20);
        addr = 2'd2; #1;
        check("R8 underrun flag", int'(rdata[2]), 1);
        held = tx_sd;
        check("R8 line holds last bit", int'(held), 1);
        ticks(20);
        check("R8 line still held", int'(tx_sd), int'(held));
        reg_write(2'd2, 8'h04);
        addr = 2'd2; #1;
        check("R8 underrun cleared", int'(rdata[2]), 0);
        tx_run = 0;
        ticks(10);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule